// File: doc/BRIEF.md
# SPI Follower Port with Glitch-Free Output Preload

This block is the follower end of an SPI link. All of its logic runs on the system clock. The serial clock, the active-low select and the incoming data line are each passed through a synchronizer chain of the same depth, so the three stay aligned in time. Edge detection then produces two single-cycle strobes. The shift strobe samples incoming data. The change strobe advances outgoing data. Which clock edge feeds which strobe is chosen at run time by the clock-polarity and clock-phase inputs, so all four SPI modes are covered. Words are `WIDTH` bits long (8 by default) and travel most-significant bit first.

On the transmit side the block keeps a holding register, which the host writes through a load strobe. A request flag tells the host when that word has been taken. While the select is inactive, the output line already shows the most-significant bit of the held word. When the select asserts, the word is copied into an output shift register. A registered multiplexer select moves the output line over to that shift register only on the first change strobe. Until then the line cannot move, in either phase setting. Consecutive words under a single select assertion are supported. Each received word is presented with a one-cycle valid pulse.

A three-state controller sequences the work. `ST_IDLE` clears the bit counter. The transition idle→arm is taken when the synchronized select becomes active. `ST_ARM` consumes the held word, and the transition arm→xfer is taken one cycle later. `ST_XFER` counts shift strobes and raises word-boundary controls. Any state returns to `ST_IDLE` as soon as the select goes inactive (arm→idle, xfer→idle), which discards a partial word.

Top module: `spi_follower`

## Requirements
- R1: The shift strobe follows the leading edge when `cpha_i`=0 and the trailing edge when `cpha_i`=1. The leading edge is rising when `cpol_i`=0 and falling when `cpol_i`=1. Input data is sampled on the shift strobe.
- R2: After `WIDTH` shift strobes, `rx_word_o` holds the received bits with the first bit in bit `WIDTH-1`, and `rx_valid_o` is high for exactly one cycle.
- R3: `miso_o` changes only on the change strobe, which falls on the edge opposite the shift strobe. The master therefore reads the transmitted word most-significant bit first.
- R4: While the select is inactive, `miso_o` equals bit `WIDTH-1` of the held word. It reflects a new load no later than two cycles after `tx_load_i`.
- R5: From select assertion until the first change strobe, `miso_o` holds the preload bit. A load during that window alters neither `miso_o` nor the word sent.
- R6: `tx_load_i` writes the holding register and clears `tx_req_o` on the next cycle. The held word is consumed, and `tx_req_o` set, at select assertion and at each word boundary.
- R7: Words sent back to back under one select assertion are each received and reported. The second outgoing word is the one loaded during the first.
- R8: Deasserting the select partway through a word discards it without a valid pulse. The next transfer starts again at bit zero.
- R9: After reset `tx_req_o`=1, `rx_valid_o`=0, `rx_word_o`=0 and `miso_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck_i | input | 1 | Serial clock from the master |
| ssel_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_word_i | input | WIDTH | Next word to transmit |
| tx_load_i | input | 1 | Write strobe for `tx_word_i` |
| tx_req_o | output | 1 | Held word has been consumed; a new one is wanted |
| rx_word_o | output | WIDTH | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_word_o` |

## Verification
The bench targets the following corner cases, and for each one it names the fault a wrong design would show:
- **Mode selection across all four modes.** A design that swaps the leading and trailing edges for any mode returns a received or transmitted word shifted by one bit.
- **The preload window under phase 1.** The bench loads a different word right after select assertion. A design whose multiplexer select is not registered, or whose preload source is not frozen, shows the new bit on the line or transmits the new word.
- **Back-to-back words in both phases.** A design that reloads the output register on the wrong boundary repeats or skips a word.
- **An aborted partial word, followed by a full one.** A design that keeps its bit counter across the abort emits a spurious valid pulse or a misaligned word.

// File: rtl/spi_follower_pkg.sv
package spi_follower_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_XFER = 2'd2
    } fsm_state_e;

    // Controls from the sequencer to the two data paths.
    typedef struct packed {
        logic clear;      // select inactive: reset per-transfer state
        logic start;      // first active cycle: consume held word
        logic sample;     // shift strobe inside a transfer
        logic last;       // shift strobe of the final bit of a word
        logic edge_zero;  // change strobe at a word boundary
        logic edge_mid;   // change strobe inside a word
    } ctrl_t;

endpackage

// File: rtl/spi_follower_sync.sv
module spi_follower_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol_i,
    input  logic cpha_i,
    input  logic sck_i,
    input  logic ssel_n_i,
    input  logic mosi_i,
    output logic active_o,
    output logic mosi_o,
    output logic shift_o,
    output logic change_o
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] ssel_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_prev;

    // One flop per stage; all three lines share the same depth.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sck_p[g]  <= 1'b0;
                ssel_p[g] <= 1'b1;
                mosi_p[g] <= 1'b0;
            end else if (g == 0) begin
                sck_p[g]  <= sck_i;
                ssel_p[g] <= ssel_n_i;
                mosi_p[g] <= mosi_i;
            end else begin
                sck_p[g]  <= sck_p[(g > 0) ? g-1 : 0];
                ssel_p[g] <= ssel_p[(g > 0) ? g-1 : 0];
                mosi_p[g] <= mosi_p[(g > 0) ? g-1 : 0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_p[STAGES-1];
    end

    logic rise, fall, lead, trail;
    always_comb begin
        rise     = sck_p[STAGES-1] & ~sck_prev;
        fall     = ~sck_p[STAGES-1] & sck_prev;
        lead     = cpol_i ? fall : rise;
        trail    = cpol_i ? rise : fall;
        shift_o  = cpha_i ? trail : lead;
        change_o = cpha_i ? lead : trail;
        active_o = ~ssel_p[STAGES-1];
        mosi_o   = mosi_p[STAGES-1];
    end

    // R1, R3: sampling and output advance never share a cycle
    assert_edges_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_o && change_o));

endmodule

// File: rtl/spi_follower_fsm.sv
module spi_follower_fsm
    import spi_follower_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active_i,
    input  logic  shift_i,
    input  logic  change_i,
    output ctrl_t ctrl_o
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    fsm_state_e state, state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Every state drives every output explicitly.
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                state_nx         = active_i ? ST_ARM : ST_IDLE;
                ctrl_o.clear     = 1'b1;
                ctrl_o.start     = 1'b0;
                ctrl_o.sample    = 1'b0;
                ctrl_o.last      = 1'b0;
                ctrl_o.edge_zero = 1'b0;
                ctrl_o.edge_mid  = 1'b0;
            end
            ST_ARM: begin
                state_nx         = active_i ? ST_XFER : ST_IDLE;
                ctrl_o.clear     = ~active_i;
                ctrl_o.start     = active_i;
                ctrl_o.sample    = 1'b0;
                ctrl_o.last      = 1'b0;
                ctrl_o.edge_zero = 1'b0;
                ctrl_o.edge_mid  = 1'b0;
            end
            ST_XFER: begin
                state_nx         = active_i ? ST_XFER : ST_IDLE;
                ctrl_o.clear     = ~active_i;
                ctrl_o.start     = 1'b0;
                ctrl_o.sample    = active_i & shift_i;
                ctrl_o.last      = active_i & shift_i & (cnt == LAST_IDX);
                ctrl_o.edge_zero = active_i & change_i & (cnt == '0);
                ctrl_o.edge_mid  = active_i & change_i & (cnt != '0);
            end
            default: begin
                state_nx         = ST_IDLE;
                ctrl_o.clear     = 1'b1;
                ctrl_o.start     = 1'b0;
                ctrl_o.sample    = 1'b0;
                ctrl_o.last      = 1'b0;
                ctrl_o.edge_zero = 1'b0;
                ctrl_o.edge_mid  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (ctrl_o.clear)  cnt <= '0;
        else if (ctrl_o.sample) cnt <= ctrl_o.last ? '0 : cnt + CW'(1);
    end

    // R8: an inactive select always leads back to idle
    assert_abort_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> state == ST_IDLE);

    // R8: idle never carries a partial bit count
    assert_idle_count_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> cnt == '0);

endmodule

// File: rtl/spi_follower_rx.sv
module spi_follower_rx
    import spi_follower_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mosi_i,
    input  ctrl_t            ctrl_i,
    output logic [WIDTH-1:0] rx_word_o,
    output logic             rx_valid_o
);

    logic [WIDTH-1:0] sr;
    logic [WIDTH-1:0] sr_next;

    always_comb sr_next = {sr[WIDTH-2:0], mosi_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr         <= '0;
            rx_word_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= ctrl_i.last;
            if (ctrl_i.clear)       sr <= '0;
            else if (ctrl_i.sample) sr <= sr_next;
            if (ctrl_i.last)        rx_word_o <= sr_next;
        end
    end

    // R2: a word needs several strobes, so valid never lasts two cycles
    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

endmodule

// File: rtl/spi_follower_tx.sv
module spi_follower_tx
    import spi_follower_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] tx_word_i,
    input  logic             tx_load_i,
    input  ctrl_t            ctrl_i,
    output logic             miso_o,
    output logic             tx_req_o
);

    logic [WIDTH-1:0] hold;
    logic [WIDTH-1:0] out_sr;
    logic             use_sr_q;   // registered multiplexer select
    logic             frozen_q;   // preload bit no longer tracks hold
    logic             pre_bit_q;
    logic             consume;

    always_comb consume = ctrl_i.start | (ctrl_i.edge_zero & use_sr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold     <= '0;
            tx_req_o <= 1'b1;
        end else if (tx_load_i) begin
            hold     <= tx_word_i;
            tx_req_o <= 1'b0;
        end else if (consume) begin
            tx_req_o <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               out_sr <= '0;
        else if (consume)         out_sr <= hold;
        else if (ctrl_i.edge_mid) out_sr <= {out_sr[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_sr_q  <= 1'b0;
            frozen_q  <= 1'b0;
            pre_bit_q <= 1'b0;
        end else begin
            if (ctrl_i.clear)                               use_sr_q <= 1'b0;
            else if (ctrl_i.edge_zero || ctrl_i.edge_mid)   use_sr_q <= 1'b1;
            if (ctrl_i.clear)      frozen_q <= 1'b0;
            else if (ctrl_i.start) frozen_q <= 1'b1;
            if (!frozen_q)         pre_bit_q <= hold[WIDTH-1];
        end
    end

    always_comb miso_o = use_sr_q ? out_sr[WIDTH-1] : pre_bit_q;

    // R6: a load always withdraws the request
    assert_load_clears_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> !tx_req_o);

    // R5: the line is frozen between select assertion and the first change strobe
    assert_preload_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !use_sr_q && $past(frozen_q)) |-> $stable(miso_o));

endmodule

// File: rtl/spi_follower.sv
module spi_follower
    import spi_follower_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic             sck_i,
    input  logic             ssel_n_i,
    input  logic             mosi_i,
    output logic             miso_o,
    input  logic [WIDTH-1:0] tx_word_i,
    input  logic             tx_load_i,
    output logic             tx_req_o,
    output logic [WIDTH-1:0] rx_word_o,
    output logic             rx_valid_o
);

    logic  active, mosi_s, shift_stb, change_stb;
    ctrl_t ctrl;

    spi_follower_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol_i   (cpol_i),
        .cpha_i   (cpha_i),
        .sck_i    (sck_i),
        .ssel_n_i (ssel_n_i),
        .mosi_i   (mosi_i),
        .active_o (active),
        .mosi_o   (mosi_s),
        .shift_o  (shift_stb),
        .change_o (change_stb)
    );

    spi_follower_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .shift_i  (shift_stb),
        .change_i (change_stb),
        .ctrl_o   (ctrl)
    );

    spi_follower_rx #(.WIDTH(WIDTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mosi_i     (mosi_s),
        .ctrl_i     (ctrl),
        .rx_word_o  (rx_word_o),
        .rx_valid_o (rx_valid_o)
    );

    spi_follower_tx #(.WIDTH(WIDTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_word_i (tx_word_i),
        .tx_load_i (tx_load_i),
        .ctrl_i    (ctrl),
        .miso_o    (miso_o),
        .tx_req_o  (tx_req_o)
    );

endmodule

// File: tb/spi_follower_tb_top.sv
module spi_follower_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;   // system clocks per serial half period
    localparam int W          = 8;

    // {cpol, cpha, master word, follower word}
    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b1, 8'h00, 8'hFF},
        {1'b0, 1'b0, 8'h81, 8'h7E},
        {1'b1, 1'b1, 8'h96, 8'h69}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpol_i = 1'b0, cpha_i = 1'b0;
    logic         sck_i = 1'b0, ssel_n_i = 1'b1, mosi_i = 1'b0;
    logic         miso_o;
    logic [W-1:0] tx_word_i = '0;
    logic         tx_load_i = 1'b0;
    logic         tx_req_o;
    logic [W-1:0] rx_word_o;
    logic         rx_valid_o;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [W-1:0] rx_last = '0, rx_prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_follower dut_i (
        .clk(clk), .rst_n(rst_n), .cpol_i(cpol_i), .cpha_i(cpha_i),
        .sck_i(sck_i), .ssel_n_i(ssel_n_i), .mosi_i(mosi_i), .miso_o(miso_o),
        .tx_word_i(tx_word_i), .tx_load_i(tx_load_i), .tx_req_o(tx_req_o),
        .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid_o) begin
            vcount  <= vcount + 1;
            rx_prev <= rx_last;
            rx_last <= rx_word_o;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] w);
        @(negedge clk); tx_word_i = w; tx_load_i = 1'b1;
        @(negedge clk); tx_load_i = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol_i = pol; cpha_i = pha; sck_i = pol;
        repeat (4) @(negedge clk);
    endtask

    task automatic select_on;
        ssel_n_i = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic select_off;
        repeat (HALF) @(negedge clk);
        ssel_n_i = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic run_bits(input int nbits, input logic [W-1:0] mw, output logic [W-1:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha_i) begin
                mosi_i = mw[W-1-i];
                repeat (HALF) @(negedge clk);
                got[W-1-i] = miso_o;
                sck_i = ~cpol_i;
                repeat (HALF) @(negedge clk);
                sck_i = cpol_i;
            end else begin
                sck_i = ~cpol_i;
                mosi_i = mw[W-1-i];
                repeat (HALF) @(negedge clk);
                got[W-1-i] = miso_o;
                sck_i = cpol_i;
                repeat (HALF) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] g1, g2;
        int vc0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 tx_req", 32'(tx_req_o), 32'd1);
        check("R9 rx_valid", 32'(rx_valid_o), 32'd0);
        check("R9 rx_word", 32'(rx_word_o), 32'd0);
        check("R9 miso", 32'(miso_o), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Table walk: all four modes
        for (int v = 0; v < NVEC; v++) begin
            set_mode(VEC[v][17], VEC[v][16]);
            load(VEC[v][7:0]);
            repeat (2) @(negedge clk);
            check("R4 preload bit", 32'(miso_o), 32'(VEC[v][7]));
            check("R6 req cleared by load", 32'(tx_req_o), 32'd0);
            vc0 = vcount;
            select_on();
            check("R6 req set at select", 32'(tx_req_o), 32'd1);
            run_bits(W, VEC[v][15:8], g1);
            select_off();
            check("R3 word seen by master", 32'(g1), 32'(VEC[v][7:0]));
            check("R1 R2 received word", 32'(rx_last), 32'(VEC[v][15:8]));
            check("R2 one valid pulse", 32'(vcount - vc0), 32'd1);
        end

        // R7: back to back words, both phases
        for (int p = 0; p < 2; p++) begin
            set_mode(1'b0, p[0]);
            load(8'h4D);
            vc0 = vcount;
            select_on();
            load(8'hE2);
            run_bits(W, 8'h1F, g1);
            run_bits(W, 8'hB0, g2);
            select_off();
            check("R7 first word out", 32'(g1), 32'h4D);
            check("R7 second word out", 32'(g2), 32'hE2);
            check("R7 first word in", 32'(rx_prev), 32'h1F);
            check("R7 second word in", 32'(rx_last), 32'hB0);
            check("R7 two valid pulses", 32'(vcount - vc0), 32'd2);
        end

        // R5: late load during the preload window, phase 1
        set_mode(1'b0, 1'b1);
        load(8'hB4);
        select_on();
        load(8'h11);
        repeat (3) @(negedge clk);
        check("R5 line frozen after late load", 32'(miso_o), 32'd1);
        run_bits(W, 8'h3A, g1);
        select_off();
        check("R5 original word sent", 32'(g1), 32'hB4);

        // R8: abort partway through, then a full word
        set_mode(1'b0, 1'b0);
        load(8'h66);
        vc0 = vcount;
        select_on();
        run_bits(3, 8'hE0, g1);
        select_off();
        check("R8 no valid on abort", 32'(vcount - vc0), 32'd0);
        load(8'h5C);
        select_on();
        run_bits(W, 8'hC9, g1);
        select_off();
        check("R8 word after abort", 32'(rx_last), 32'hC9);
        check("R8 one valid after abort", 32'(vcount - vc0), 32'd1);
        check("R8 out word after abort", 32'(g1), 32'h5C);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule